// File: doc/BRIEF.md
# Power-Capability Change Alert

This block raises a level alert toward a host processor whenever the power that is available or requested on a port may be about to change. The power-delivery policy engine reports such moments as single-cycle pulses: the port entering the unattached state as a source, entering the unattached state as a sink, a power request going out, an accept being sent in answer to a power-role swap, and a fast role swap. Any one of these pulses sets a sticky flag. The host usually answers by reducing its own power draw until it has looked at the new power capabilities again.

The flag does not follow the events. It stays set until the host writes to the interrupt-clear register, which reaches this block as a one-cycle clear pulse. The same flag also appears as a readable interrupt status bit, so the host sees in status exactly what the alert pin shows. If an event and a clear arrive in the same cycle, the event wins, so no event is lost.

Top module: `pcap_alert`

## Requirements
- R1: While reset is active and in the first cycle after reset is released, `alert_o` and `irq_stat_o` are both 0.
- R2: A pulse on `evt_i[0]` (entered unattached-as-source) makes `alert_o` 1 from the clock edge that samples the pulse.
- R3: A pulse on `evt_i[1]` (entered unattached-as-sink) makes `alert_o` 1 from the clock edge that samples the pulse.
- R4: A pulse on `evt_i[2]` (request message sent) or on `evt_i[3]` (accept sent to a power-role swap) makes `alert_o` 1 from the clock edge that samples it.
- R5: A pulse on `evt_i[4]` (fast role swap occurred) makes `alert_o` 1 from the clock edge that samples it.
- R6: Any combination of event bits high in the same cycle sets the alert exactly as a single event does.
- R7: Once set, `alert_o` stays 1 after the event pulse ends, for as long as `clr_i` stays 0.
- R8: A `clr_i` pulse with no event in the same cycle returns `alert_o` to 0 at the next clock edge.
- R9: When any event bit and `clr_i` are high in the same cycle, `alert_o` is 1 after that edge.
- R10: A `clr_i` pulse while `alert_o` is 0 and no event is present leaves `alert_o` at 0.
- R11: `irq_stat_o` equals `alert_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | NUM_EVT (5) | Event pulses: bit 0 unattached-source, bit 1 unattached-sink, bit 2 request sent, bit 3 swap accept sent, bit 4 fast role swap |
| clr_i | input | 1 | One-cycle pulse from a write to the interrupt-clear register |
| alert_o | output | 1 | Alert to the host, active high |
| irq_stat_o | output | 1 | Sticky interrupt status bit that the host reads |

## Verification
The bench starts from both flag states and applies every event pattern, with and without a clear, then checks the flag at that edge and again one idle cycle later. A design that lets the clear win would lose an event raised in the same cycle as a clear. A design that drives the alert straight from the events would drop it once the pulse ends. A design that OR-reduces only some event bits would miss one single-bit pattern. A clear that toggles the flag instead of zeroing it would raise a false alert when the flag is already low. The status bit is compared to the alert at every sample, so a status copy that lags or ignores the clear is caught.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int unsigned EVT_UNATT_SRC = 0;
  localparam int unsigned EVT_UNATT_SNK = 1;
  localparam int unsigned EVT_REQ_SENT  = 2;
  localparam int unsigned EVT_PRS_ACPT  = 3;
  localparam int unsigned EVT_FRS       = 4;
  localparam int unsigned EVT_COUNT     = 5;
  localparam int unsigned RST_STAGES    = 2;
endpackage

// File: rtl/pcap_rst_sync.sv
module pcap_rst_sync #(
  parameter int unsigned STAGES = pcap_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pcap_evt_merge.sv
module pcap_evt_merge #(
  parameter int unsigned NUM_EVT = pcap_pkg::EVT_COUNT
) (
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               any_o
);
  logic [NUM_EVT:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_or
    assign chain[g+1] = chain[g] | evt_i[g];
  end
  assign any_o = chain[NUM_EVT];
endmodule

// File: rtl/pcap_sticky_flag.sv
module pcap_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic mirror_o
);
  logic flag_q, flag_d;
  logic mirror_q, mirror_d;
  logic upd_en;

  // Update only when something asks for a change; set has priority.
  always_comb begin
    upd_en   = set_i | clr_i;
    flag_d   = flag_q;
    mirror_d = mirror_q;
    if (upd_en) begin
      flag_d   = set_i;
      mirror_d = set_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      mirror_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      mirror_q <= mirror_d;
    end
  end

  assign flag_o   = flag_q;
  assign mirror_o = mirror_q;

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !set_i && !clr_i) |=> flag_q);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> flag_q);
  a_r10_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_i) |=> !flag_q);
endmodule

// File: rtl/pcap_alert.sv
module pcap_alert #(
  parameter int unsigned NUM_EVT = pcap_pkg::EVT_COUNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  output logic               alert_o,
  output logic               irq_stat_o
);
  logic rst_sync_n;
  logic evt_any;

  pcap_rst_sync #(.STAGES(pcap_pkg::RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcap_evt_merge #(.NUM_EVT(NUM_EVT)) i_evt_merge (
    .evt_i (evt_i),
    .any_o (evt_any)
  );

  pcap_sticky_flag i_flag (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (evt_any),
    .clr_i    (clr_i),
    .flag_o   (alert_o),
    .mirror_o (irq_stat_o)
  );

  a_r6_any_event_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|evt_i) |=> alert_o);
  a_r11_mirror: assert property (@(posedge clk) disable iff (!rst_sync_n)
    alert_o == irq_stat_o);
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_sync_n |=> (!alert_o && !irq_stat_o));
endmodule

// File: tb/test_pcap_alert.sv
module test_pcap_alert;
  localparam int unsigned NE = 5;

  logic          clk;
  logic          rst_n;
  logic [NE-1:0] evt;
  logic          clr;
  logic          alert, stat;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  pcap_alert #(.NUM_EVT(NE)) i_pcap_alert (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .clr_i      (clr),
    .alert_o    (alert),
    .irq_stat_o (stat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic exp_v);
    checks++;
    if (alert !== exp_v) begin
      failures++;
      $display("FAIL %s alert actual=%b expected=%b", req, alert, exp_v);
    end
    checks++;
    if (stat !== alert) begin
      failures++;
      $display("FAIL R11 irq_stat actual=%b expected=%b", stat, alert);
    end
  endtask

  task automatic step(input logic [NE-1:0] e, input logic c);
    evt = e;
    clr = c;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [NE-1:0] e, input logic c, input logic prev);
    if (e != 0 && c)       return "R9";
    if (e == 0 && c)       return prev ? "R8" : "R10";
    if (e == 0)            return prev ? "R7" : "R10";
    if ($countones(e) > 1) return "R6";
    if (e[0])              return "R2";
    if (e[1])              return "R3";
    if (e[4])              return "R5";
    return "R4";
  endfunction

  initial begin
    evt   = '0;
    clr   = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    for (int prev = 0; prev < 2; prev++) begin
      for (int c = 0; c < 2; c++) begin
        for (int p = 0; p < (1 << NE); p++) begin
          logic expv;
          step('0, 1'b1);
          if (prev != 0) step(NE'(1) << (p % NE), 1'b0);
          check(prev != 0 ? "R7" : "R8", prev != 0);
          expv = (p != 0) || ((prev != 0) && (c == 0));
          step(NE'(p), c[0]);
          check(tag_of(NE'(p), c[0], prev[0]), expv);
          step('0, 1'b0);
          check(expv ? "R7" : "R10", expv);
        end
      end
    end
    step(5'b00100, 1'b0);
    check("R4", 1'b1);
    step('0, 1'b0);
    step('0, 1'b0);
    check("R7", 1'b1);
    step('0, 1'b1);
    check("R8", 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule